// File: doc/BRIEF.md
# Serial Flash Status and Power-Mode Controller

This block keeps the volatile status state of a serial flash device: the write enable latch, a busy flag that follows the self-timed program/erase engine, and a sticky error flag that holds the result of the last finished operation. It assembles these three flags into the status byte that the read path shifts out. It gates which decoded commands the rest of the device may act on.

The block also runs the deep power-down sequence. A power-down command arms the block only while no self-timed operation is running. The block then enters the powered-down state on the chip-select rising edge that closes that command frame. While powered down, the resume command is the only one honoured.

The block also applies the hold abort rule. If chip select is released while hold is asserted, the block issues a one-cycle abort pulse, clears the write enable latch and drops any armed power-down.

Command strobes are one-cycle pulses from the command decoder, synchronous to `clk`. Chip select and hold are active low and already synchronised to `clk`.

Top module: `flash_stat_pwr_ctrl`

## Requirements
- R1: After reset, WEL is 0, the status byte is 0x00, power-down is 0, the abort pulse is 0 and command accept is 1.
- R2: Outside power-down, a write-enable strobe sets WEL on the next cycle. A write-disable strobe clears it on the next cycle. If both arrive together, the disable wins.
- R3: The modify grant (program, erase, protect, unprotect or status write) is high in the same cycle as the modify strobe only when WEL is 1 and the block is not powered down.
- R4: An engine done pulse clears WEL on the next cycle, with priority over a write-enable strobe in the same cycle.
- R5: On an engine done pulse, the error flag (status bit 5) takes the value of the engine error input on the next cycle. It holds that value until the next done pulse.
- R6: Status bit 0 equals the engine busy input delayed by one cycle. Status bit 1 is WEL. All other status bits are 0.
- R7: A power-down strobe is dropped while the engine busy input or status bit 0 is high. The following chip-select rising edge then leaves power-down at 0.
- R8: A power-down strobe accepted while idle, followed by a chip-select rising edge with hold high, sets power-down on the cycle after that edge. Command accept is the inverse of power-down.
- R9: While powered down, the write-enable, write-disable, power-down and modify strobes have no effect: WEL holds and the modify grant stays 0.
- R10: While powered down, a resume strobe clears power-down on the next cycle.
- R11: A chip-select rising edge while hold is low raises the abort output for exactly one cycle, clears WEL and cancels an armed power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, synchronised |
| hold_n | input | 1 | Hold, active low, synchronised |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_pdown | input | 1 | Deep power-down command strobe |
| cmd_resume | input | 1 | Resume-from-power-down strobe |
| cmd_modify | input | 1 | Program/erase/protect/status-write request strobe |
| eng_busy | input | 1 | Self-timed engine is running |
| eng_done | input | 1 | Engine finished an operation (one-cycle pulse) |
| eng_err | input | 1 | Engine error result, valid with eng_done |
| wel | output | 1 | Write enable latch |
| status | output | STAT_W | Assembled status byte |
| pdown | output | 1 | Device is in deep power-down |
| cmd_accept | output | 1 | Commands may be acted upon |
| mod_grant | output | 1 | Modify request is allowed |
| op_abort | output | 1 | One-cycle abort pulse to the engine |

## Verification
The bench aims at collisions between strobes: enable and disable together, and enable in the same cycle as a done pulse. A design with the wrong priority would leave WEL set after a finished operation. It issues a power-down while the engine is busy and checks that the next chip-select edge does not power the block down. A design that queued the request would fall asleep late. It releases chip select under hold, both with WEL set and with a power-down armed. A design that missed the rule would keep WEL, skip the abort pulse or enter power-down. It also sends every strobe while powered down, where a leaky gate would change WEL or grant a modify.

// File: rtl/flash_stat_pwr_pkg.sv
package flash_stat_pwr_pkg;
   typedef enum logic [1:0] {
      PM_AWAKE = 2'd0,
      PM_ARMED = 2'd1,
      PM_ASLEEP = 2'd2
   } pmode_e;

   typedef struct packed {
      logic wren;
      logic wrdi;
      logic pdown;
      logic resume;
      logic modify;
   } cmd_strobes_t;
endpackage

// File: rtl/fsp_cs_edge.sv
module fsp_cs_edge #(
   parameter bit ABORT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic hold_n,
   output logic cs_rise,
   output logic abort_evt,
   output logic abort_out
);
   logic cs_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_prev <= 1'b1;
      else        cs_prev <= cs_n;
   end

   assign cs_rise   = cs_n & ~cs_prev;
   assign abort_evt = cs_rise & ~hold_n;

   generate
      if (ABORT_REG) begin : g_abort_reg
         logic abort_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) abort_q <= 1'b0;
            else        abort_q <= abort_evt;
         end
         assign abort_out = abort_q;
      end else begin : g_abort_comb
         assign abort_out = abort_evt;
      end
   endgenerate
endmodule

// File: rtl/fsp_wel.sv
module fsp_wel
   import flash_stat_pwr_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  cmd_strobes_t cmd,
   input  logic         asleep,
   input  logic         done,
   input  logic         abort_evt,
   output logic         wel_q
);
   logic wel_d;

   always_comb begin
      wel_d = wel_q;
      if (abort_evt || done) wel_d = 1'b0;
      else if (!asleep) begin
         if (cmd.wrdi)      wel_d = 1'b0;
         else if (cmd.wren) wel_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wel_q <= 1'b0;
      else        wel_q <= wel_d;
   end
endmodule

// File: rtl/fsp_pmode.sv
module fsp_pmode
   import flash_stat_pwr_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  cmd_strobes_t cmd,
   input  logic         busy_any,
   input  logic         cs_rise,
   input  logic         hold_n,
   output logic         asleep
);
   pmode_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PM_AWAKE:  if (cmd.pdown && !busy_any) state_d = PM_ARMED;
         PM_ARMED:  if (cs_rise) state_d = hold_n ? PM_ASLEEP : PM_AWAKE;
         PM_ASLEEP: if (cmd.resume) state_d = PM_AWAKE;
         default:   state_d = PM_AWAKE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PM_AWAKE;
      else        state_q <= state_d;
   end

   assign asleep = (state_q == PM_ASLEEP);
endmodule

// File: rtl/fsp_status.sv
module fsp_status #(
   parameter int STAT_W   = 8,
   parameter int BUSY_POS = 0,
   parameter int WEL_POS  = 1,
   parameter int EPE_POS  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_busy,
   input  logic              done,
   input  logic              err,
   input  logic              wel,
   output logic              busy_q,
   output logic [STAT_W-1:0] status
);
   logic epe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         epe_q  <= 1'b0;
      end else begin
         busy_q <= eng_busy;
         if (done) epe_q <= err;
      end
   end

   generate
      for (genvar b = 0; b < STAT_W; b++) begin : g_bit
         if (b == BUSY_POS)     begin : g_busy assign status[b] = busy_q; end
         else if (b == WEL_POS) begin : g_wel  assign status[b] = wel;    end
         else if (b == EPE_POS) begin : g_epe  assign status[b] = epe_q;  end
         else                   begin : g_zero assign status[b] = 1'b0;   end
      end
   endgenerate
endmodule

// File: rtl/flash_stat_pwr_ctrl.sv
module flash_stat_pwr_ctrl
   import flash_stat_pwr_pkg::*;
#(
   parameter int STAT_W    = 8,
   parameter int BUSY_POS  = 0,
   parameter int WEL_POS   = 1,
   parameter int EPE_POS   = 5,
   parameter bit ABORT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              hold_n,
   input  logic              cmd_wren,
   input  logic              cmd_wrdi,
   input  logic              cmd_pdown,
   input  logic              cmd_resume,
   input  logic              cmd_modify,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic              eng_err,
   output logic              wel,
   output logic [STAT_W-1:0] status,
   output logic              pdown,
   output logic              cmd_accept,
   output logic              mod_grant,
   output logic              op_abort
);
   localparam int MAX_POS = STAT_W - 1;

   generate
      if (STAT_W < 3) begin : g_chk_w
         $error("STAT_W must hold three flags");
      end
      if (BUSY_POS > MAX_POS || WEL_POS > MAX_POS || EPE_POS > MAX_POS) begin : g_chk_rng
         $error("flag position outside the status word");
      end
      if (BUSY_POS == WEL_POS || BUSY_POS == EPE_POS || WEL_POS == EPE_POS) begin : g_chk_dup
         $error("flag positions must differ");
      end
   endgenerate

   cmd_strobes_t cmd;
   logic cs_rise, abort_evt, asleep, busy_q, busy_any;

   assign cmd = '{wren: cmd_wren, wrdi: cmd_wrdi, pdown: cmd_pdown,
                  resume: cmd_resume, modify: cmd_modify};
   assign busy_any = eng_busy | busy_q;

   fsp_cs_edge #(.ABORT_REG(ABORT_REG)) u_edge (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n),
      .cs_rise(cs_rise), .abort_evt(abort_evt), .abort_out(op_abort)
   );

   fsp_wel u_wel (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .asleep(asleep),
      .done(eng_done), .abort_evt(abort_evt), .wel_q(wel)
   );

   fsp_pmode u_pmode (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .busy_any(busy_any),
      .cs_rise(cs_rise), .hold_n(hold_n), .asleep(asleep)
   );

   fsp_status #(
      .STAT_W(STAT_W), .BUSY_POS(BUSY_POS), .WEL_POS(WEL_POS), .EPE_POS(EPE_POS)
   ) u_status (
      .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .done(eng_done),
      .err(eng_err), .wel(wel), .busy_q(busy_q), .status(status)
   );

   assign pdown      = asleep;
   assign cmd_accept = ~asleep;
   assign mod_grant  = cmd_modify & wel & ~asleep;
endmodule

// File: rtl/flash_stat_pwr_chk.sv
module flash_stat_pwr_chk #(
   parameter int STAT_W   = 8,
   parameter int BUSY_POS = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              hold_n,
   input logic              cmd_wren,
   input logic              cmd_wrdi,
   input logic              cmd_resume,
   input logic              cmd_modify,
   input logic              eng_busy,
   input logic              eng_done,
   input logic              wel,
   input logic [STAT_W-1:0] status,
   input logic              pdown,
   input logic              mod_grant,
   input logic              op_abort
);
   a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wren && !cmd_wrdi && !eng_done && !pdown && !cs_n |=> wel);

   a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> !wel);

   a_r6_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> status[BUSY_POS] == $past(eng_busy));

   a_r9_no_grant_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      pdown |-> !mod_grant);

   a_r9_wel_holds_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      pdown && !eng_done && !cs_n |=> $stable(wel));

   a_r10_resume_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      pdown && cmd_resume |=> !pdown);

   a_r8_entry_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdown) |-> $past(cs_n) && $past(hold_n));

   a_r11_abort_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
      op_abort |-> !wel);

   a_r11_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      op_abort |=> !op_abort);

   a_r3_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      mod_grant |-> wel && cmd_modify);
endmodule

bind flash_stat_pwr_ctrl flash_stat_pwr_chk #(.STAT_W(STAT_W), .BUSY_POS(BUSY_POS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n),
   .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_resume(cmd_resume),
   .cmd_modify(cmd_modify), .eng_busy(eng_busy), .eng_done(eng_done),
   .wel(wel), .status(status), .pdown(pdown), .mod_grant(mod_grant),
   .op_abort(op_abort)
);

// File: tb/tb_flash_stat_pwr_ctrl.sv
module tb_flash_stat_pwr_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, hold_n = 1'b1;
   logic cmd_wren = 0, cmd_wrdi = 0, cmd_pdown = 0, cmd_resume = 0, cmd_modify = 0;
   logic eng_busy = 0, eng_done = 0, eng_err = 0;
   logic wel, pdown, cmd_accept, mod_grant, op_abort;
   logic [7:0] status;

   int checks = 0, fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   flash_stat_pwr_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n),
      .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_pdown(cmd_pdown),
      .cmd_resume(cmd_resume), .cmd_modify(cmd_modify),
      .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
      .wel(wel), .status(status), .pdown(pdown), .cmd_accept(cmd_accept),
      .mod_grant(mod_grant), .op_abort(op_abort)
   );

   // Behavioural reference: state 0 awake, 1 armed, 2 asleep
   bit m_csq = 1, m_wel = 0, m_busy = 0, m_epe = 0, m_abort = 0;
   int m_state = 0;

   always @(posedge clk) begin
      bit rise, abrt, bsy;
      if (!rst_n) begin
         m_csq = 1; m_wel = 0; m_busy = 0; m_epe = 0; m_abort = 0; m_state = 0;
      end else begin
         rise = cs_n && !m_csq;
         abrt = rise && !hold_n;
         bsy  = eng_busy || m_busy;
         if (abrt || eng_done) m_wel = 0;
         else if (m_state != 2) begin
            if (cmd_wrdi) m_wel = 0;
            else if (cmd_wren) m_wel = 1;
         end
         if (eng_done) m_epe = eng_err;
         m_busy = eng_busy;
         case (m_state)
            0: if (cmd_pdown && !bsy) m_state = 1;
            1: if (rise) m_state = hold_n ? 2 : 0;
            default: if (cmd_resume) m_state = 0;
         endcase
         m_abort = abrt;
         m_csq = cs_n;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n && !finished) begin
      bit pd;
      pd = (m_state == 2);
      chk("R2 wel", wel, m_wel);
      chk("R6 status", status, {2'b00, m_epe, 3'b000, m_wel, m_busy});
      chk("R8 pdown", pdown, pd);
      chk("R8 cmd_accept", cmd_accept, !pd);
      chk("R3 mod_grant", mod_grant, cmd_modify && m_wel && !pd);
      chk("R11 op_abort", op_abort, m_abort);
   end

   task automatic step(int n = 1);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #400000;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      step(3);
      rst_n = 1;
      #1;
      // R1 reset values
      chk("R1 wel", wel, 0);
      chk("R1 status", status, 0);
      chk("R1 pdown", pdown, 0);
      chk("R1 op_abort", op_abort, 0);
      chk("R1 cmd_accept", cmd_accept, 1);
      step();
      // R2 enable, R3 grant
      cs_n = 0; cmd_wren = 1; step(); cmd_wren = 0; cs_n = 1; step();
      cs_n = 0; cmd_modify = 1; step(); cmd_modify = 0; cs_n = 1;
      // R6 busy, R5 error capture, R4 done clears
      eng_busy = 1; step(3);
      eng_busy = 0; eng_done = 1; eng_err = 1; step(); eng_done = 0; eng_err = 0; step(2);
      // R2 both strobes: disable wins
      cmd_wren = 1; step(); cmd_wren = 1; cmd_wrdi = 1; step(); cmd_wren = 0; cmd_wrdi = 0; step();
      // R4 done beats wren; R5 clean done clears error
      cmd_wren = 1; eng_done = 1; step(); cmd_wren = 0; eng_done = 0; step(2);
      // R7 power-down while busy is dropped
      eng_busy = 1; step(); cs_n = 0; cmd_pdown = 1; step(); cmd_pdown = 0; cs_n = 1; step(3);
      eng_busy = 0; eng_done = 1; step(); eng_done = 0; step(2);
      // R8 framed power-down
      cmd_wren = 1; step(); cmd_wren = 0;
      cs_n = 0; cmd_pdown = 1; step(); cmd_pdown = 0; step(); cs_n = 1; step(3);
      // R9 strobes ignored while asleep
      cs_n = 0; cmd_wrdi = 1; step(); cmd_wrdi = 0; cmd_modify = 1; step(); cmd_modify = 0;
      cmd_pdown = 1; step(); cmd_pdown = 0; cs_n = 1; step(2);
      // R10 resume
      cs_n = 0; cmd_resume = 1; step(); cmd_resume = 0; cs_n = 1; step(2);
      // R11 hold abort clears WEL
      cmd_wren = 1; step(); cmd_wren = 0; cs_n = 0; step(); hold_n = 0; step(); cs_n = 1; step(); hold_n = 1; step(2);
      // R11 hold abort cancels armed power-down
      cs_n = 0; cmd_pdown = 1; step(); cmd_pdown = 0; hold_n = 0; step(); cs_n = 1; step(); hold_n = 1; step(3);
      // Pseudo-random mix over all inputs
      begin
         logic [15:0] lfsr = 16'hACE1;
         for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cs_n = lfsr[0] | lfsr[1];
            hold_n = lfsr[2] | lfsr[3] | lfsr[4];
            cmd_wren = (lfsr[7:5] == 3'd1);
            cmd_wrdi = (lfsr[7:5] == 3'd2);
            cmd_pdown = (lfsr[7:5] == 3'd3);
            cmd_resume = (lfsr[7:5] == 3'd4);
            cmd_modify = (lfsr[7:5] == 3'd5);
            eng_busy = lfsr[8] & lfsr[9];
            eng_done = (lfsr[12:10] == 3'd7);
            eng_err = lfsr[11] ^ lfsr[13];
            step();
         end
      end
      summary();
   end
endmodule